// File: doc/BRIEF.md
# Single-Precision Floating-Point Predicate Comparator

This block compares two 32-bit IEEE-754 single-precision operands under one of seven predicates, picked by a 3-bit select. It produces a one-bit condition result meant to set a branch condition bit. It also produces an invalid-operation indication, which a separate status unit collects. The compare is combinational and is followed by one register stage, so both outputs appear one clock after the operands and select are applied. The block accepts a new compare every cycle.

There are two kinds of predicate. The signaling ordered tests (less-than, less-or-equal) treat any NaN operand as an invalid operation. The quiet tests (equal, unordered, and the three "unordered-or" forms) flag invalid only for a signaling NaN. Every predicate treats the two signed zeros as equal. When at least one operand is NaN the operands are unordered, and none of less, equal or greater holds.

Top module: `fpcmp_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `cond_o` and `invalid_o` are 0 after that edge.
- R2: The outputs after clock edge k reflect `op_a`, `op_b` and `pred_sel` as sampled at edge k. The latency is exactly one cycle and a new compare is accepted every cycle.
- R3: Select 0 (equal) is quiet. It is true when the operands are ordered and equal, with +0 equal to -0. A NaN operand gives false. Invalid is raised only when an operand is a signaling NaN.
- R4: Select 1 (less-than) and select 2 (less-or-equal) are signaling. If either operand is NaN, the result is false and invalid is 1. Ordered operands never raise invalid.
- R5: Ordered values are ranked by sign-magnitude. Any negative value is below any positive value. Among negatives, the larger magnitude is the smaller value. The infinities rank at the two ends.
- R6: Select 3 (unordered) is 1 exactly when at least one operand is NaN. Invalid is raised only for a signaling NaN.
- R7: Select 4 is true when the operands are equal or unordered. Select 5 is true when a < b or the operands are unordered. Select 6 is true unless a > b. All three are quiet, raising invalid only for a signaling NaN.
- R8: Select 7 is reserved. It gives 0 on both outputs, whatever the operands.
- R9: An operand is NaN when exponent bits [30:23] are all ones and mantissa bits [22:0] are nonzero. A NaN is signaling when mantissa bit 22 is 0. An infinity (zero mantissa) is an ordered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | Left operand, IEEE single precision |
| op_b | input | 32 | Right operand, IEEE single precision |
| pred_sel | input | 3 | Predicate: 0 eq, 1 lt, 2 le, 3 un, 4 ueq, 5 ult, 6 ule, 7 reserved |
| cond_o | output | 1 | Registered predicate result |
| invalid_o | output | 1 | Registered invalid-operation indication |

## Verification
Each result is due exactly one clock edge after its operands and select are applied. The driver changes inputs on the falling edge, and the registered outputs update on the next rising edge. The driver pushes the predicted pair into a queue when it applies the inputs. The monitor pops one entry a quarter period after each rising edge, when the outputs for that entry are settled, so every entry is compared against the cycle it belongs to. The predictions come from an independent model that maps each operand to an unsigned ordering key. Directed vectors cover signed zeros, infinities, both NaN kinds and the reserved select, and a pseudo-random stream sweeps every select.

// File: rtl/fpcmp_pkg.sv
// Package: shared predicate encoding for the floating-point comparator.
// Assumes a 3-bit select; code values are part of the block's interface.
package fpcmp_pkg;
    typedef enum logic [2:0] {
        PRED_EQ   = 3'd0,
        PRED_LT   = 3'd1,
        PRED_LE   = 3'd2,
        PRED_UN   = 3'd3,
        PRED_UEQ  = 3'd4,
        PRED_ULT  = 3'd5,
        PRED_ULE  = 3'd6,
        PRED_NONE = 3'd7
    } pred_e;
endpackage

// File: rtl/fpcmp_classify.sv
// Module: classifies one floating-point operand (NaN, signaling NaN, zero)
// and splits it into sign and magnitude. Purely combinational.
// Assumes the IEEE layout: sign at the top, then exponent, then mantissa.
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [MAG_W:0]   op,
    output logic             sign,
    output logic [MAG_W-1:0] mag,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    // Field split and class decode for one operand.
    always_comb begin
        sign    = op[MAG_W];
        mag     = op[MAG_W-1:0];
        expo    = op[MAG_W-1:MAN_W];
        mant    = op[MAN_W-1:0];
        is_nan  = (&expo) && (|mant);
        is_snan = is_nan && !mant[MAN_W-1];
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
// Module: derives the relation between two classified operands: exactly one
// of less, equal, greater or unordered. Signed zeros are treated as equal.
// Assumes the inputs come from fpcmp_classify.
module fpcmp_order #(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             nan_a,
    input  logic             nan_b,
    input  logic             snan_a,
    input  logic             snan_b,
    input  logic             zero_a,
    input  logic             zero_b,
    output logic             rel_lt,
    output logic             rel_eq,
    output logic             rel_gt,
    output logic             rel_un,
    output logic             any_snan
);
    logic mag_lt, mag_eq, a_below;

    // Sign-magnitude ranking; the magnitude order flips for two negatives.
    always_comb begin
        rel_un   = nan_a || nan_b;
        any_snan = snan_a || snan_b;
        mag_lt   = mag_a < mag_b;
        mag_eq   = mag_a == mag_b;
        if (zero_a && zero_b)
            a_below = 1'b0;
        else if (sign_a != sign_b)
            a_below = sign_a;
        else if (sign_a)
            a_below = !mag_lt && !mag_eq;
        else
            a_below = mag_lt;
        rel_eq = !rel_un && ((zero_a && zero_b) || (mag_eq && sign_a == sign_b));
        rel_lt = !rel_un && a_below;
        rel_gt = !rel_un && !rel_eq && !a_below;
    end
endmodule

// File: rtl/fpcmp_select.sv
// Module: maps a relation onto the selected predicate and decides whether the
// compare is an invalid operation (signaling forms: any NaN; quiet: sNaN).
module fpcmp_select
    import fpcmp_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       rel_lt,
    input  logic       rel_eq,
    input  logic       rel_gt,
    input  logic       rel_un,
    input  logic       any_snan,
    output logic       flag,
    output logic       inv
);
    // Predicate decode and exception choice.
    always_comb begin
        flag = 1'b0;
        inv  = 1'b0;
        case (pred_e'(sel))
            PRED_EQ:  begin flag = rel_eq;           inv = any_snan; end
            PRED_LT:  begin flag = rel_lt;           inv = rel_un;   end
            PRED_LE:  begin flag = rel_lt || rel_eq; inv = rel_un;   end
            PRED_UN:  begin flag = rel_un;           inv = any_snan; end
            PRED_UEQ: begin flag = rel_eq || rel_un; inv = any_snan; end
            PRED_ULT: begin flag = rel_lt || rel_un; inv = any_snan; end
            PRED_ULE: begin flag = !rel_gt;          inv = any_snan; end
            default:  begin flag = 1'b0;             inv = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/fpcmp_top.sv
// Module: single-precision predicate comparator with one output register.
// Assumes operands are held for the sampling edge; one result per cycle,
// latency one clock. Synchronous active-low reset clears both outputs.
module fpcmp_top #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int MAG_W = EXP_W + MAN_W,
    localparam int W     = MAG_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   pred_sel,
    output logic         cond_o,
    output logic         invalid_o
);
    logic [W-1:0]     ops    [2];
    logic             sgn_v  [2];
    logic [MAG_W-1:0] mag_v  [2];
    logic             nan_v  [2];
    logic             snan_v [2];
    logic             zero_v [2];
    logic rel_lt, rel_eq, rel_gt, rel_un, any_snan, flag_c, inv_c;

    // Operand fan-in for the per-operand classifiers.
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op(ops[i]), .sign(sgn_v[i]), .mag(mag_v[i]),
            .is_nan(nan_v[i]), .is_snan(snan_v[i]), .is_zero(zero_v[i])
        );
    end

    fpcmp_order #(.MAG_W(MAG_W)) u_ord (
        .sign_a(sgn_v[0]), .sign_b(sgn_v[1]), .mag_a(mag_v[0]), .mag_b(mag_v[1]),
        .nan_a(nan_v[0]), .nan_b(nan_v[1]), .snan_a(snan_v[0]), .snan_b(snan_v[1]),
        .zero_a(zero_v[0]), .zero_b(zero_v[1]),
        .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_gt(rel_gt), .rel_un(rel_un),
        .any_snan(any_snan)
    );

    fpcmp_select u_sel (
        .sel(pred_sel), .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_gt(rel_gt),
        .rel_un(rel_un), .any_snan(any_snan), .flag(flag_c), .inv(inv_c)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_o    <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            cond_o    <= flag_c;
            invalid_o <= inv_c;
        end
    end

    // R1: reset leaves both outputs low.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!cond_o && !invalid_o));
    // R5: exactly one relation holds for any operand pair.
    a_r5_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel_lt, rel_eq, rel_gt, rel_un}) == 1);
    // R4: signaling compares with a NaN give false and invalid.
    a_r4_signal_nan: assert property (@(posedge clk) disable iff (!rst_n)
        ((pred_sel == 3'd1 || pred_sel == 3'd2) && rel_un) |=> (!cond_o && invalid_o));
    // R3: quiet equal with only quiet NaNs stays silent and false.
    a_r3_quiet_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel == 3'd0 && rel_un && !any_snan) |=> (!cond_o && !invalid_o));
    // R6: unordered test follows the NaN detection one cycle later.
    a_r6_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel == 3'd3) |=> (cond_o == $past(rel_un)));
    // R7: unordered-or forms are true on unordered operands.
    a_r7_unord_true: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel >= 3'd4 && pred_sel <= 3'd6 && rel_un) |=> cond_o);
    // R8: reserved select yields nothing.
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel == 3'd7) |=> (!cond_o && !invalid_o));
endmodule

// File: tb/fpcmp_top_tb.sv
// Scoreboard bench: the driver applies a vector on the falling edge and
// queues its prediction; the monitor pops and compares after each rising edge.
module fpcmp_top_tb;
    typedef struct {
        logic  flag;
        logic  inv;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  pred_sel = '0;
    logic        cond_o, invalid_o;

    exp_t exp_q[$];
    int   n_vec = 0, n_bad = 0;
    bit   done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    fpcmp_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .pred_sel(pred_sel), .cond_o(cond_o), .invalid_o(invalid_o)
    );

    always #10 clk = ~clk;

    function automatic logic is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // Ordering key: unsigned compare of keys matches the numeric order.
    function automatic logic [31:0] okey(input logic [31:0] x);
        if (x[30:0] == 0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [2:0] s);
        exp_t e;
        logic un, sn, lt, eq, gt;
        un = is_nan(a) || is_nan(b);
        sn = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
        lt = !un && (okey(a) < okey(b));
        eq = !un && (okey(a) == okey(b));
        gt = !un && (okey(a) > okey(b));
        case (s)
            3'd0: begin e.flag = eq;      e.inv = sn; e.tag = "R3"; end
            3'd1: begin e.flag = lt;      e.inv = un; e.tag = "R4"; end
            3'd2: begin e.flag = lt || eq; e.inv = un; e.tag = "R4"; end
            3'd3: begin e.flag = un;      e.inv = sn; e.tag = "R6"; end
            3'd4: begin e.flag = eq || un; e.inv = sn; e.tag = "R7"; end
            3'd5: begin e.flag = lt || un; e.inv = sn; e.tag = "R7"; end
            3'd6: begin e.flag = !gt;     e.inv = sn; e.tag = "R7"; end
            default: begin e.flag = 1'b0; e.inv = 1'b0; e.tag = "R8"; end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; pred_sel = s;
        e = model(a, b, s);
        if (tag != "") e.tag = {tag, "/", e.tag};
        exp_q.push_back(e);
    endtask

    task automatic all_preds(input logic [31:0] a, input logic [31:0] b,
                             input string tag);
        for (int s = 0; s < 8; s++) drive(a, b, 3'(s), tag);
    endtask

    function automatic logic [31:0] pick(input logic [31:0] r);
        case (r[31:29])
            3'd0: return {r[0], 8'hFF, 23'h0};
            3'd1: return {r[0], 8'hFF, r[1], r[22:2] | 21'h1, r[3]};
            3'd2: return {r[0], 31'h0};
            3'd3: return {r[28], r[7:0] ^ 8'h80, 23'h0};
            default: return r;
        endcase
    endfunction

    // Monitor: compares one queued prediction per cycle after the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (cond_o !== e.flag || invalid_o !== e.inv) begin
                n_bad++;
                $display("FAIL %s: got cond=%b inv=%b, expected cond=%b inv=%b",
                         e.tag, cond_o, invalid_o, e.flag, e.inv);
            end
        end
    end

    initial begin : wdog
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs low even with a vector that would be true.
        op_a = 32'h7FC0_0000; pred_sel = 3'd3;
        repeat (3) @(posedge clk);
        #5;
        n_vec++;
        if (cond_o !== 1'b0 || invalid_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got cond=%b inv=%b, expected cond=0 inv=0", cond_o, invalid_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R3/R5: signed zeros equal under every predicate.
        all_preds(32'h0000_0000, 32'h8000_0000, "R5");
        all_preds(32'h3F80_0000, 32'h4000_0000, "R5");   // 1.0 vs 2.0
        all_preds(32'hBF80_0000, 32'hC000_0000, "R5");   // -1.0 vs -2.0
        all_preds(32'hBF80_0000, 32'h3F80_0000, "R5");   // -1 vs +1
        all_preds(32'hFF80_0000, 32'h7F80_0000, "R9");   // -inf vs +inf
        all_preds(32'h7F80_0000, 32'h7F80_0000, "R9");   // inf equal
        all_preds(32'h7FC0_0000, 32'h3F80_0000, "R9");   // quiet NaN
        all_preds(32'h3F80_0000, 32'h7F80_0001, "R9");   // signaling NaN
        all_preds(32'hFFA0_0000, 32'h7FC0_0001, "R9");   // sNaN and qNaN
        // R2: back-to-back alternating vectors with no idle cycle.
        for (int i = 0; i < 16; i++)
            drive(i[0] ? 32'h7FC0_0000 : 32'h3F80_0000, 32'h3F80_0000, 3'd3, "R2");
        // Pseudo-random sweep of all selects.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            ra = pick(lfsr);
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            rb = (lfsr[4:0] == 0) ? ra : pick(lfsr);
            drive(ra, rb, lfsr[10:8], "");
        end
        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule